// File: doc/BRIEF.md
# Four-Bit Function-Select Arithmetic/Logic Slice

A combinational slice that applies one of 32 operations to two 4-bit active-high operands. A mode input picks between two sets of 16 codes. In logic mode the slice computes a bitwise function of the two operands and keeps every carry out of the result. In arithmetic mode the slice adds two derived operand words and can add one more from a carry input.

The carry input and the three carry-related outputs are active low. A low carry input means "add one". A low ripple carry output means a carry leaves the slice. Low group generate and low group propagate let an outside look-ahead unit form carries over many slices without waiting for the ripple output. Neither group output depends on the carry input. An equality flag rises whenever the result is all ones. In subtract mode with no carry added, this flag marks equal operands.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode`=1, `result` is a bitwise function of `a_in` and `b_in` chosen by `fsel`. The codes are 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 0000, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 1111, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With `logic_mode`=0 and `carry_in_n`=1, `result` is the low 4 bits of the base sum given by `fsel` (nB = ~B, 4 bits). The codes are 0000 A, 0001 A|B, 0010 A|nB, 0011 15, 0100 A+(A&nB), 0101 (A|B)+(A&nB), 0110 A+nB, 0111 (A&nB)+15, 1000 A+(A&B), 1001 A+B, 1010 (A|nB)+(A&B), 1011 (A&B)+15, 1100 A+A, 1101 (A|B)+A, 1110 (A|nB)+A, 1111 A+15.
- R3: In arithmetic mode, `carry_in_n`=0 adds one to the base sum. `result` is the low 4 bits of the total.
- R4: Code 0110 in arithmetic mode gives A-B-1 with `carry_in_n`=1 and A-B with `carry_in_n`=0. `carry_out_n` is low exactly when no borrow occurs.
- R5: `carry_out_n` is low exactly when the base sum plus the carry exceeds 15. This holds in both modes.
- R6: `grp_gen_n` is low exactly when the base sum alone exceeds 15. When it is high, `grp_prop_n` is low exactly when the base sum equals 15. Neither output depends on `carry_in_n`.
- R7: `all_ones` is high exactly when `result` is 1111.
- R8: In logic mode, `carry_in_n` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4 | Operand A |
| b_in | input | 4 | Operand B |
| fsel | input | 4 | Operation code |
| logic_mode | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_in_n | input | 1 | Carry input, active low |
| result | output | 4 | Operation result |
| carry_out_n | output | 1 | Ripple carry output, active low |
| grp_prop_n | output | 1 | Group propagate, active low |
| grp_gen_n | output | 1 | Group generate, active low |
| all_ones | output | 1 | High when result is all ones |

## Verification
The sweep covers every operand pair, code, mode and carry value. Any single wrong operand term in one of the 32 codes therefore changes some `result` value. Carries that cross all four bits are a sensitive case: the "minus one" codes with a carry added wrap to zero and must drive `carry_out_n` low. A look-ahead term with a missing product would pass most values and fail only there. The group outputs are checked with the carry input in both states, so any leak of the carry into generate or propagate shows up as a mismatch between the two halves. The logic-mode checks with the carry asserted catch a result that still adds the carry when it should not. The subtract code at equal operands exposes an inverted borrow sense and a wrong equality flag.

// File: rtl/alu4_slice.sv
module alu4_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   fsel,
  input  logic         logic_mode,
  input  logic         carry_in_n,
  output logic [W-1:0] result,
  output logic         carry_out_n,
  output logic         grp_prop_n,
  output logic         grp_gen_n,
  output logic         all_ones
);

  logic [W-1:0] gen_t, prop_t;
  logic [W:0]   cy;
  logic         grp_g;
  logic         acc, run;

  // two addends of the base sum; gen_t is always a subset of prop_t
  assign gen_t  = (a_in & b_in & {W{fsel[3]}}) | (a_in & ~b_in & {W{fsel[2]}});
  assign prop_t = a_in | (b_in & {W{fsel[0]}}) | (~b_in & {W{fsel[1]}});

  // flat look-ahead: each carry is an OR of generate/propagate products
  always_comb begin
    cy    = '0;
    cy[0] = ~carry_in_n;
    acc   = 1'b0;
    run   = 1'b1;
    for (int i = 1; i <= W; i++) begin
      acc = 1'b0;
      run = 1'b1;
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & gen_t[j]);
        run = run & prop_t[j];
      end
      cy[i] = acc | (run & cy[0]);
    end
    grp_g = acc;
  end

  assign result      = logic_mode ? ~(gen_t ^ prop_t) : (gen_t ^ prop_t ^ cy[W-1:0]);
  assign carry_out_n = ~cy[W];
  assign grp_gen_n   = ~grp_g;
  assign grp_prop_n  = ~(&prop_t);
  assign all_ones    = &result;

  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, gen_t} + {1'b0, prop_t} + {{W{1'b0}}, ~carry_in_n};

  always_comb begin
    if (!$isunknown({a_in, b_in, fsel, logic_mode, carry_in_n})) begin
      if (!logic_mode) begin
        p_sum_matches_r3: assert ({~carry_out_n, result} == ref_sum)
          else $error("lookahead sum mismatch");
      end
      if (!logic_mode && fsel == 4'b0110 && carry_in_n) begin
        p_sub_equal_r4: assert (all_ones == (a_in == b_in))
          else $error("equality in subtract mode wrong");
      end
      p_gen_forces_carry_r5: assert (grp_gen_n || !carry_out_n)
        else $error("generate without carry out");
      p_no_pg_no_carry_r6: assert (!(grp_gen_n && grp_prop_n) || carry_out_n)
        else $error("carry out without generate or propagate");
    end
  end

endmodule

// File: tb/alu4_slice_test.sv
module alu4_slice_test;

  logic       clk = 1'b0;
  logic [3:0] a, b, s, res;
  logic       m, cin_n, cout_n, p_n, g_n, eq;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  alu4_slice uut (
    .a_in(a), .b_in(b), .fsel(s), .logic_mode(m), .carry_in_n(cin_n),
    .result(res), .carry_out_n(cout_n), .grp_prop_n(p_n), .grp_gen_n(g_n),
    .all_ones(eq)
  );

  function automatic int base_sum(input int sc, input int av, input int bv);
    int nb;
    nb = (~bv) & 15;
    case (sc)
      0:  return av;
      1:  return av | bv;
      2:  return av | nb;
      3:  return 15;
      4:  return av + (av & nb);
      5:  return (av | bv) + (av & nb);
      6:  return av + nb;
      7:  return (av & nb) + 15;
      8:  return av + (av & bv);
      9:  return av + bv;
      10: return (av | nb) + (av & bv);
      11: return (av & bv) + 15;
      12: return av + av;
      13: return (av | bv) + av;
      14: return (av | nb) + av;
      default: return av + 15;
    endcase
  endfunction

  function automatic int logic_ref(input int sc, input int av, input int bv);
    int r;
    case (sc)
      0:  r = ~av;
      1:  r = ~(av | bv);
      2:  r = ~av & bv;
      3:  r = 0;
      4:  r = ~(av & bv);
      5:  r = ~bv;
      6:  r = av ^ bv;
      7:  r = av & ~bv;
      8:  r = ~av | bv;
      9:  r = ~(av ^ bv);
      10: r = bv;
      11: r = av & bv;
      12: r = 15;
      13: r = av | ~bv;
      14: r = av | bv;
      default: r = av;
    endcase
    return r & 15;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d s=%0d m=%0d cin_n=%0d actual=%0d expected=%0d",
               tag, a, b, s, m, cin_n, act, exp);
    end
  endtask

  initial begin
    a = 0; b = 0; s = 0; m = 0; cin_n = 1;
    @(negedge clk);
    check(res == 4'd0, "R2 idle pass-through", res, 0);
    check(cout_n == 1'b1, "R5 idle carry", cout_n, 1);
    for (int idx = 0; idx < 16384; idx++) begin
      @(posedge clk);
      a = idx[3:0]; b = idx[7:4]; s = idx[11:8]; m = idx[12]; cin_n = idx[13];
      @(negedge clk);
      begin
        int ns, tot, er;
        ns  = base_sum(int'(s), int'(a), int'(b));
        tot = ns + (cin_n ? 0 : 1);
        er  = m ? logic_ref(int'(s), int'(a), int'(b)) : (tot & 15);
        if (m && !cin_n)       check(res == er[3:0], "R8 logic ignores carry", res, er);
        else if (m)            check(res == er[3:0], "R1 logic result", res, er);
        else if (s == 4'd6)    check(res == er[3:0], "R4 subtract result", res, er);
        else if (!cin_n)       check(res == er[3:0], "R3 carry adds one", res, er);
        else                   check(res == er[3:0], "R2 arithmetic result", res, er);
        if (!m && s == 4'd6)   check(cout_n == !(int'(a) + (cin_n ? 0 : 1) > int'(b)),
                                     "R4 borrow sense", cout_n, !(int'(a) + (cin_n ? 0 : 1) > int'(b)));
        check(cout_n == !(tot > 15), "R5 carry out", cout_n, !(tot > 15));
        check(g_n == !(ns > 15), "R6 group generate", g_n, !(ns > 15));
        if (ns <= 15) check(p_n == !(ns == 15), "R6 group propagate", p_n, !(ns == 15));
        check(eq == (er == 15), "R7 all ones flag", eq, er == 15);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("Watchdog expired before sweep ended");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule